// File: doc/BRIEF.md
# RTC Time Snapshot Latch

This block holds a coherent copy of the seven real-time-clock time bytes (seconds, minutes, hours, day of week, day of month, month, year) for a serial slave that reads them out one byte per transaction. It watches the live time bytes, a flag that is high while the clock hardware is updating, a strobe that marks a software write to a time byte, and a flag from the serial slave that is high while no transfer is under way.

The copy is refreshed on a clock edge only when the time is steady and the bus is idle. A byte handed to the serial interface therefore never changes while a read is in progress. A software write blocks capture in its own cycle and for a guard window after it, so a half-written value is never latched. All seven bytes are loaded on the same edge. A byte selector picks one byte of the copy for the serial shift logic. Rollover between two separate byte reads is left to software.

Top module: `rtc_time_snapshot`

## Requirements
- R1: Byte k of the snapshot sits at `snap_time[8k+7:8k]`. The order is seconds=0, minutes=1, hours=2, day of week=3, day of month=4, month=5, year=6.
- R2: While `rst_n` is low the snapshot reads all zeros. The first qualifying edge after reset loads the live time.
- R3: On an edge where `bus_idle` is 1, `hw_update` is 0, `sw_wr` is 0 and no write falls in the guard window, the snapshot takes the value of `live_time`. The new value is visible after that edge.
- R4: On an edge where `hw_update` is 1, the snapshot keeps its value.
- R5: A `sw_wr` pulse blocks capture on its own edge and on the next SW_GUARD edges. With the default SW_GUARD=1, that is the following edge.
- R6: On an edge where `bus_idle` is 0 (a read is in progress), the snapshot keeps its value.
- R7: All seven bytes load on the same edge, so the snapshot always equals `live_time` as it was in a single cycle.
- R8: `rd_byte` is snapshot byte `rd_sel` for `rd_sel` 0 to 6. For `rd_sel` = 7 (reserved) it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_time | input | 56 | Live RTC time bytes, laid out as in R1 |
| hw_update | input | 1 | Clock hardware update in progress |
| sw_wr | input | 1 | Software write to a time byte in this cycle |
| bus_idle | input | 1 | Serial slave has no transfer in progress |
| rd_sel | input | 3 | Byte index for readout |
| snap_time | output | 56 | Latched time bytes |
| rd_byte | output | 8 | Selected snapshot byte |

## Verification
The bench builds the block with BYTE_W=8 and SW_GUARD=1. With these values every ordered pair of the eight gate-input patterns (`hw_update`, `sw_wr`, `bus_idle`) can be driven on consecutive edges. All 64 pairs are swept, so every way a write's guard cycle can overlap the other blockers is reached. The live bytes change on every cycle, which exposes any byte that loads on the wrong edge. The readout selector is rotated through all eight codes, including the reserved one.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int RTC_NUM_BYTES = 7;

  typedef enum logic [2:0] {
    IDX_SEC  = 3'd0,
    IDX_MIN  = 3'd1,
    IDX_HOUR = 3'd2,
    IDX_DOW  = 3'd3,
    IDX_DOM  = 3'd4,
    IDX_MON  = 3'd5,
    IDX_YEAR = 3'd6,
    IDX_RSVD = 3'd7
  } rtc_idx_e;

  // capture rule: bus quiet and time not moving
  function automatic logic capture_ok(input logic hw_busy, input logic wr_now,
                                      input logic wr_guard, input logic idle);
    return idle & ~hw_busy & ~wr_now & ~wr_guard;
  endfunction
endpackage

// File: rtl/rtc_change_gate.sv
module rtc_change_gate #(
  parameter int SW_GUARD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_update,
  input  logic sw_wr,
  input  logic bus_idle,
  output logic time_moving,
  output logic cap_en
);
  import rtc_snap_pkg::*;

  localparam int GW = (SW_GUARD < 1) ? 1 : $clog2(SW_GUARD + 1);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(SW_GUARD);

  logic [GW-1:0] guard_cnt;
  logic          guard_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                guard_cnt <= '0;
    else if (sw_wr)            guard_cnt <= GUARD_LOAD;
    else if (guard_cnt != '0)  guard_cnt <= guard_cnt - 1'b1;
  end

  assign guard_active = (guard_cnt != '0);
  assign time_moving  = hw_update | sw_wr | guard_active;
  assign cap_en       = capture_ok(hw_update, sw_wr, guard_active, bus_idle);

  // R5
  sw_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> !cap_en);
endmodule

// File: rtl/rtc_snap_store.sv
module rtc_snap_store #(
  parameter int BYTE_W = 8,
  parameter int NB     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [NB*BYTE_W-1:0] live,
  output logic [NB*BYTE_W-1:0] snap
);
  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap[g*BYTE_W +: BYTE_W] <= '0;
        else if (cap_en) snap[g*BYTE_W +: BYTE_W] <= live[g*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> snap == $past(live));
  // R7
  hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(snap));
endmodule

// File: rtl/rtc_byte_pick.sv
module rtc_byte_pick #(
  parameter int BYTE_W = 8,
  parameter int NB     = 7,
  parameter int SEL_W  = 3
) (
  input  logic [NB*BYTE_W-1:0] snap,
  input  logic [SEL_W-1:0]     sel,
  output logic [BYTE_W-1:0]    byte_out
);
  always_comb begin
    byte_out = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel == SEL_W'(i)) byte_out = snap[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/rtc_time_snapshot.sv
module rtc_time_snapshot #(
  parameter int BYTE_W   = 8,
  parameter int SW_GUARD = 1,
  localparam int NB      = rtc_snap_pkg::RTC_NUM_BYTES,
  localparam int SEL_W   = $clog2(NB + 1),
  localparam int TW      = NB * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    live_time,
  input  logic             hw_update,
  input  logic             sw_wr,
  input  logic             bus_idle,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [TW-1:0]    snap_time,
  output logic [BYTE_W-1:0] rd_byte
);
  logic time_moving;
  logic cap_en;

  rtc_change_gate #(.SW_GUARD(SW_GUARD)) u_gate (
    .clk(clk), .rst_n(rst_n), .hw_update(hw_update), .sw_wr(sw_wr),
    .bus_idle(bus_idle), .time_moving(time_moving), .cap_en(cap_en)
  );

  rtc_snap_store #(.BYTE_W(BYTE_W), .NB(NB)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .live(live_time), .snap(snap_time)
  );

  rtc_byte_pick #(.BYTE_W(BYTE_W), .NB(NB), .SEL_W(SEL_W)) u_pick (
    .snap(snap_time), .sel(rd_sel), .byte_out(rd_byte)
  );

  // R4
  hw_update_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_update |=> $stable(snap_time));
  // R6
  bus_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> $stable(snap_time));
  // R4
  moving_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_moving |=> $stable(snap_time));
  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_W'(NB)) |-> (rd_byte == '0));
endmodule

// File: tb/test_rtc_time_snapshot.sv
module test_rtc_time_snapshot;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 7;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [55:0] live_time = '0;
  logic        hw_update = 0, sw_wr = 0, bus_idle = 0;
  logic [2:0]  rd_sel = 0;
  logic [55:0] snap_time;
  logic [7:0]  rd_byte;

  int checks = 0, failures = 0;
  logic [55:0] exp_snap = '0;
  logic        prev_sw = 0;
  int          stamp = 0;
  bit          done = 0;

  rtc_time_snapshot i_rtc_time_snapshot (
    .clk(clk), .rst_n(rst_n), .live_time(live_time), .hw_update(hw_update),
    .sw_wr(sw_wr), .bus_idle(bus_idle), .rd_sel(rd_sel),
    .snap_time(snap_time), .rd_byte(rd_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [55:0] make_time(int n);
    logic [55:0] v;
    for (int k = 0; k < NB; k++) v[k*8 +: 8] = 8'((n * 37 + k * 11 + 5) % 256);
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(logic hw, logic sw, logic idle);
    string tag;
    logic  qual;
    logic [55:0] lv;
    stamp++;
    lv = make_time(stamp);
    live_time = lv; hw_update = hw; sw_wr = sw; bus_idle = idle;
    rd_sel = 3'(stamp % 8);
    qual = idle & ~hw & ~sw & ~prev_sw;
    if (hw) tag = "R4";
    else if (sw || prev_sw) tag = "R5";
    else if (!idle) tag = "R6";
    else tag = "R3";
    @(posedge clk);
    if (qual) exp_snap = lv;
    prev_sw = sw;
    @(negedge clk);
    check(tag, 64'(snap_time), 64'(exp_snap));
    if (rd_sel == 3'd7) check("R8", 64'(rd_byte), 64'd0);
    else begin
      check("R8", 64'(rd_byte), 64'(exp_snap[rd_sel*8 +: 8]));
      check("R1", 64'(snap_time[rd_sel*8 +: 8]), 64'(exp_snap[rd_sel*8 +: 8]));
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    live_time = make_time(99);
    bus_idle = 1;
    repeat (3) @(negedge clk);
    // R2: reset state is zero even with a qualifying input
    check("R2", 64'(snap_time), 64'd0);
    rst_n = 1;
    exp_snap = '0;
    prev_sw = 0;
    // R2: first qualifying edge loads
    cyc(0, 0, 1);
    check("R2", 64'(snap_time), 64'(make_time(stamp)));

    // R7: consecutive captures with changing live time
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1);
      check("R7", 64'(snap_time), 64'(make_time(stamp)));
    end

    // R5: guard edge after a write
    cyc(0, 0, 1);
    cyc(0, 1, 1);
    check("R5", 64'(snap_time), 64'(make_time(stamp - 1)));
    cyc(0, 0, 1);
    check("R5", 64'(snap_time), 64'(make_time(stamp - 2)));
    cyc(0, 0, 1);
    check("R5", 64'(snap_time), 64'(make_time(stamp)));

    // sweep every ordered pair of gate patterns
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        cyc(a[2], a[1], a[0]);
        cyc(b[2], b[1], b[0]);
        cyc(0, 0, 1);
        cyc(0, 0, 1);
      end
    end

    // R8: every selector code against the snapshot
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      if (s == 7) check("R8", 64'(rd_byte), 64'd0);
      else        check("R8", 64'(rd_byte), 64'(exp_snap[s*8 +: 8]));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule